// File: doc/BRIEF.md
# Programmable Network Status LED Driver

This block drives the status LEDs of a 10 Mbps Ethernet controller. It has a set of identical programmable LED channels and one fixed link LED. Each programmable channel holds a small configuration word. The word enables any mix of three event sources: receive activity, magic-packet detection and full-duplex link status. It also holds a switch that lengthens short events into a visible blink. The channel's LED is lit by the OR of its enabled sources. Software reads back the live, unstretched value of that OR in the top bit of the channel's register.

The full-duplex link source is qualified by the port that is active. On twisted pair it needs both link pass and the duplex enable. On the attachment-unit port it needs both the duplex enable and the attachment-unit duplex bit. On the serial port it needs only the duplex enable. The fixed link LED shows twisted-pair link integrity. It is blanked when the twisted-pair port runs full duplex, the attachment-unit duplex bit is clear, and any channel uses the full-duplex source. A board can therefore fit a half-duplex link LED and a full-duplex link LED, and only one of them is lit at a time.

All LED pins are active low and come from flops.

Top module: `net_led_driver`

## Requirements
- R1: After reset, every programmable channel register reads 16'h0084, meaning receive activity and stretching are enabled and no source is active. Every LED pin is high (off).
- R2: A channel's source is the OR of the enabled sources. Bit 15 of the channel's register reads that OR live, in the same cycle, before any stretching.
- R3: A channel's register uses these bits: bit 9 enables magic packet, bit 8 enables full-duplex link, bit 7 enables stretching, bit 2 enables receive. Bits 14:10, 6:3 and 1:0 always read zero, whatever was written.
- R4: The full-duplex link source depends on port_sel (0 twisted pair, 1 attachment unit, 2 serial, 3 none). Twisted pair needs link_pass and fd_en. Attachment unit needs fd_en and aui_fd. Serial needs fd_en. Code 3 gives zero.
- R5: With stretching off, a channel's pin is low exactly in the cycle after a cycle in which its source is true.
- R6: With stretching on, a single-cycle rise of the source keeps the pin low for exactly STRETCH_CYCLES cycles, starting the cycle after the rise.
- R7: A new rise of the source during a stretch restarts the full STRETCH_CYCLES on-time from that rise.
- R8: Register address 0 reads bit 15 as the live link LED state, and bits 14:0 as zero. led_link_n goes low in the cycle after that state is one.
- R9: The link LED state is link_pass, forced to zero when all of these hold: port_sel is 0, fd_en is 1, aui_fd is 0, and bit 8 is set in any channel.
- R10: Writes to address 0 have no effect. A write to address i+1 changes only channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_evt | input | 1 | Receive activity strobe |
| mpkt_evt | input | 1 | Magic packet received strobe |
| link_pass | input | 1 | Twisted-pair link test pass |
| port_sel | input | 2 | Active port: 0 twisted pair, 1 attachment unit, 2 serial, 3 none |
| fd_en | input | 1 | Full-duplex enable |
| aui_fd | input | 1 | Attachment-unit full-duplex enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | 0 is the link register, i+1 is channel i |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| led_prog_n | output | NUM_PROG | Programmable channel LEDs, active low |
| led_link_n | output | 1 | Link LED, active low |

## Verification
A corrupted enable bit shows in two places. It changes the register readback at once, and it changes the pin one cycle after the next event. A wrong stretch counter shows only as a pin that goes dark one or more cycles early or late. Because of that, the bench counts every cycle of each blink, including a restart in the middle of a blink. A wrong duplex qualifier or mask term shows on the live readback bit in the same cycle, and on the pin one cycle later. The bench therefore sweeps every combination of port, duplex bits and link pass.

// File: rtl/net_led_pkg.sv
package net_led_pkg;
   typedef enum logic [1:0] {
      PORT_TP   = 2'd0,
      PORT_AUI  = 2'd1,
      PORT_GPSI = 2'd2,
      PORT_NONE = 2'd3
   } port_e;

   localparam int REG_W    = 16;
   localparam int BIT_LIVE = 15;
   localparam int BIT_MP   = 9;
   localparam int BIT_FDLS = 8;
   localparam int BIT_PSE  = 7;
   localparam int BIT_RCV  = 2;

   typedef struct packed {
      logic mp;
      logic fdls;
      logic pse;
      logic rcv;
   } led_cfg_t;

   localparam led_cfg_t CFG_RESET = '{mp: 1'b0, fdls: 1'b0, pse: 1'b1, rcv: 1'b1};
endpackage

// File: rtl/led_fd_qual.sv
module led_fd_qual
   import net_led_pkg::*;
(
   input  logic [1:0] port_sel,
   input  logic       fd_en,
   input  logic       aui_fd,
   input  logic       link_pass,
   output logic       fd_link,
   output logic       tp_fd
);
   always_comb begin
      unique case (port_e'(port_sel))
         PORT_TP:   fd_link = link_pass & fd_en;
         PORT_AUI:  fd_link = fd_en & aui_fd;
         PORT_GPSI: fd_link = fd_en;
         default:   fd_link = 1'b0;
      endcase
   end

   assign tp_fd = (port_e'(port_sel) == PORT_TP) & fd_en;
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
   parameter int STRETCH_CYCLES = 16,
   parameter bit HAS_STRETCH    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   input  logic pse,
   output logic led_on
);
   localparam int CNT_W = (STRETCH_CYCLES > 2) ? $clog2(STRETCH_CYCLES) : 1;
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STRETCH_CYCLES - 1);

   logic led_q;
   assign led_on = led_q;

   generate
      if (HAS_STRETCH) begin : g_stretch
         logic             src_q;
         logic [CNT_W-1:0] cnt;
         logic             rise;

         assign rise = src & ~src_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               src_q <= 1'b0;
               cnt   <= '0;
               led_q <= 1'b0;
            end else begin
               src_q <= src;
               if (!pse)
                  cnt <= '0;
               else if (rise)
                  cnt <= RELOAD;
               else if (cnt != '0)
                  cnt <= cnt - 1'b1;
               led_q <= src | (pse & (cnt != '0));
            end
         end
      end else begin : g_plain
         logic unused_pse;
         assign unused_pse = pse;

         always_ff @(posedge clk) begin
            if (!rst_n)
               led_q <= 1'b0;
            else
               led_q <= src;
         end
      end
   endgenerate
endmodule

// File: rtl/led_prog_chan.sv
module led_prog_chan
   import net_led_pkg::*;
#(
   parameter int STRETCH_CYCLES = 16,
   parameter bit HAS_STRETCH    = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  led_cfg_t wr_cfg,
   input  logic     rx_evt,
   input  logic     mpkt_evt,
   input  logic     fd_link,
   output led_cfg_t cfg,
   output logic     src,
   output logic     led_on
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg <= CFG_RESET;
      else if (wr_en)
         cfg <= wr_cfg;
   end

   assign src = (cfg.rcv & rx_evt) | (cfg.mp & mpkt_evt) | (cfg.fdls & fd_link);

   led_stretch #(
      .STRETCH_CYCLES(STRETCH_CYCLES),
      .HAS_STRETCH   (HAS_STRETCH)
   ) u_stretch (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src),
      .pse   (cfg.pse),
      .led_on(led_on)
   );
endmodule

// File: rtl/net_led_driver.sv
module net_led_driver
   import net_led_pkg::*;
#(
   parameter int NUM_PROG       = 3,
   parameter int STRETCH_CYCLES = 16,
   parameter bit HAS_STRETCH    = 1'b1,
   parameter int ADDR_W         = $clog2(NUM_PROG + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_evt,
   input  logic                mpkt_evt,
   input  logic                link_pass,
   input  logic [1:0]          port_sel,
   input  logic                fd_en,
   input  logic                aui_fd,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [15:0]         reg_wdata,
   output logic [15:0]         reg_rdata,
   output logic [NUM_PROG-1:0] led_prog_n,
   output logic                led_link_n
);
   generate
      if (NUM_PROG < 1) begin : g_bad_num
         $error("NUM_PROG must be at least 1");
      end
      if (STRETCH_CYCLES < 2) begin : g_bad_stretch
         $error("STRETCH_CYCLES must be at least 2");
      end
      if ((1 << ADDR_W) < NUM_PROG + 1) begin : g_bad_addr
         $error("ADDR_W too narrow for NUM_PROG channels");
      end
   endgenerate

   logic                fd_link;
   logic                tp_fd;
   led_cfg_t            cfg_vec [NUM_PROG];
   logic [NUM_PROG-1:0] src_vec;
   logic [NUM_PROG-1:0] pse_vec;
   logic [NUM_PROG-1:0] fdls_vec;
   logic [NUM_PROG-1:0] on_vec;
   logic                fdls_any;
   logic                link_live;
   logic                link_q;
   led_cfg_t            wr_cfg;
   logic                unused_wbits;

   assign wr_cfg = '{mp:   reg_wdata[BIT_MP],
                     fdls: reg_wdata[BIT_FDLS],
                     pse:  reg_wdata[BIT_PSE],
                     rcv:  reg_wdata[BIT_RCV]};
   assign unused_wbits = ^{reg_wdata[15:10], reg_wdata[6:3], reg_wdata[1:0]};

   led_fd_qual u_fdq (
      .port_sel (port_sel),
      .fd_en    (fd_en),
      .aui_fd   (aui_fd),
      .link_pass(link_pass),
      .fd_link  (fd_link),
      .tp_fd    (tp_fd)
   );

   generate
      for (genvar i = 0; i < NUM_PROG; i++) begin : g_chan
         led_prog_chan #(
            .STRETCH_CYCLES(STRETCH_CYCLES),
            .HAS_STRETCH   (HAS_STRETCH)
         ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_we && (reg_addr == ADDR_W'(i + 1))),
            .wr_cfg  (wr_cfg),
            .rx_evt  (rx_evt),
            .mpkt_evt(mpkt_evt),
            .fd_link (fd_link),
            .cfg     (cfg_vec[i]),
            .src     (src_vec[i]),
            .led_on  (on_vec[i])
         );
         assign pse_vec[i]    = cfg_vec[i].pse;
         assign fdls_vec[i]   = cfg_vec[i].fdls;
         assign led_prog_n[i] = ~on_vec[i];
      end
   endgenerate

   assign fdls_any  = |fdls_vec;
   assign link_live = link_pass & ~(tp_fd & ~aui_fd & fdls_any);

   always_ff @(posedge clk) begin
      if (!rst_n)
         link_q <= 1'b0;
      else
         link_q <= link_live;
   end
   assign led_link_n = ~link_q;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == '0)
         reg_rdata[BIT_LIVE] = link_live;
      for (int i = 0; i < NUM_PROG; i++) begin
         if (reg_addr == ADDR_W'(i + 1))
            reg_rdata = {src_vec[i], 5'b0, cfg_vec[i].mp, cfg_vec[i].fdls,
                         cfg_vec[i].pse, 4'b0, cfg_vec[i].rcv, 2'b0};
      end
   end
endmodule

// File: rtl/net_led_driver_chk.sv
module net_led_driver_chk #(
   parameter int NUM_PROG = 3,
   parameter int ADDR_W   = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [15:0]         reg_rdata,
   input logic [NUM_PROG-1:0] led_prog_n,
   input logic                led_link_n,
   input logic [NUM_PROG-1:0] src_vec,
   input logic [NUM_PROG-1:0] pse_vec,
   input logic                link_live,
   input logic                tp_fd,
   input logic                aui_fd,
   input logic                fdls_any
);
   assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != '0) |-> (reg_rdata[14:10] == '0 && reg_rdata[6:3] == '0 && reg_rdata[1:0] == '0));

   assert_link_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == '0) |-> (reg_rdata[15] == link_live && reg_rdata[14:0] == '0));

   assert_link_pin_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      link_live |=> !led_link_n);

   assert_link_pin_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !link_live |=> led_link_n);

   assert_link_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tp_fd && !aui_fd && fdls_any) |=> led_link_n);

   generate
      for (genvar i = 0; i < NUM_PROG; i++) begin : g_chk
         assert_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !pse_vec[i] |=> (led_prog_n[i] == !$past(src_vec[i])));

         assert_stretch_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pse_vec[i] && $rose(src_vec[i])) |=> !led_prog_n[i]);

         assert_src_lit_R2: assert property (@(posedge clk) disable iff (!rst_n)
            src_vec[i] |=> !led_prog_n[i]);
      end
   endgenerate
endmodule

bind net_led_driver net_led_driver_chk #(
   .NUM_PROG(NUM_PROG),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .led_prog_n(led_prog_n),
   .led_link_n(led_link_n),
   .src_vec   (src_vec),
   .pse_vec   (pse_vec),
   .link_live (link_live),
   .tp_fd     (tp_fd),
   .aui_fd    (aui_fd),
   .fdls_any  (fdls_any)
);

// File: tb/net_led_driver_test.sv
`timescale 1ns/1ps
module net_led_driver_test;
   localparam int NUM_PROG = 3;
   localparam int S        = 16;
   localparam int AW       = 2;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                rx_evt, mpkt_evt, link_pass, fd_en, aui_fd, reg_we;
   logic [1:0]          port_sel;
   logic [AW-1:0]       reg_addr;
   logic [15:0]         reg_wdata, reg_rdata;
   logic [NUM_PROG-1:0] led_prog_n;
   logic                led_link_n;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   net_led_driver #(.NUM_PROG(NUM_PROG), .STRETCH_CYCLES(S)) uut (
      .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .mpkt_evt(mpkt_evt),
      .link_pass(link_pass), .port_sel(port_sel), .fd_en(fd_en), .aui_fd(aui_fd),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .led_prog_n(led_prog_n), .led_link_n(led_link_n)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; rx_evt = 0; mpkt_evt = 0; link_pass = 0; fd_en = 0; aui_fd = 0;
      port_sel = 2'd3; reg_we = 0; reg_addr = '0; reg_wdata = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      tick();
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      reg_addr = AW'(a);
      #1;
      d = reg_rdata;
   endtask

   function automatic logic fd_exp(input int p, input logic fd, input logic au, input logic lp);
      case (p)
         0: return lp & fd;
         1: return fd & au;
         2: return fd;
         default: return 1'b0;
      endcase
   endfunction

   task automatic test_reset();
      logic [15:0] d;
      do_reset();
      for (int i = 1; i <= NUM_PROG; i++) begin
         rd(i, d);
         check("R1 channel default", d, 16'h0084);
      end
      rd(0, d);
      check("R1 link reg default", d, 16'h0000);
      check("R1 prog pins off", 16'(led_prog_n), 16'(3'b111));
      check("R1 link pin off", 16'(led_link_n), 16'h0001);
   endtask

   task automatic test_follow();
      logic [15:0] d;
      do_reset();
      wr(1, 16'h0004);
      rx_evt = 1'b1;
      rd(1, d);
      check("R2 live bit rx", d, 16'h8004);
      check("R5 no early change", 16'(led_prog_n[0]), 16'h1);
      tick();
      check("R5 pin on after one cycle", 16'(led_prog_n[0]), 16'h0);
      rx_evt = 1'b0;
      #1;
      check("R5 pin held until edge", 16'(led_prog_n[0]), 16'h0);
      tick();
      check("R5 pin off after one cycle", 16'(led_prog_n[0]), 16'h1);
      wr(1, 16'h0200);
      rx_evt = 1'b1;
      rd(1, d);
      check("R2 disabled rx ignored", d, 16'h0200);
      tick();
      check("R2 disabled rx pin off", 16'(led_prog_n[0]), 16'h1);
      rx_evt = 1'b0; mpkt_evt = 1'b1;
      rd(1, d);
      check("R2 magic live", d, 16'h8200);
      tick();
      check("R2 magic pin on", 16'(led_prog_n[0]), 16'h0);
      mpkt_evt = 1'b0;
      wr(1, 16'h0204);
      rx_evt = 1'b1; mpkt_evt = 1'b1;
      rd(1, d);
      check("R2 both sources OR", d, 16'h8204);
      rx_evt = 1'b0;
      rd(1, d);
      check("R2 one of two sources", d, 16'h8204);
      mpkt_evt = 1'b0;
   endtask

   task automatic test_stretch();
      do_reset();
      rx_evt = 1'b1;
      tick();
      rx_evt = 1'b0;
      for (int k = 1; k <= S; k++) begin
         check("R6 stretched on", 16'(led_prog_n[1]), 16'h0);
         if (k < S) tick();
      end
      tick();
      check("R6 off after stretch", 16'(led_prog_n[1]), 16'h1);
   endtask

   task automatic test_restart();
      do_reset();
      rx_evt = 1'b1;
      tick();
      rx_evt = 1'b0;
      repeat (4) tick();
      check("R7 on before retrigger", 16'(led_prog_n[2]), 16'h0);
      rx_evt = 1'b1;
      tick();
      rx_evt = 1'b0;
      for (int k = 1; k < S; k++) begin
         tick();
         check("R7 restarted on", 16'(led_prog_n[2]), 16'h0);
      end
      tick();
      check("R7 off after restart", 16'(led_prog_n[2]), 16'h1);
   endtask

   task automatic test_fd_ports();
      logic [15:0] d;
      logic        e;
      do_reset();
      wr(3, 16'h0100);
      for (int p = 0; p < 4; p++)
         for (int f = 0; f < 2; f++)
            for (int a = 0; a < 2; a++)
               for (int l = 0; l < 2; l++) begin
                  port_sel = 2'(p); fd_en = f[0]; aui_fd = a[0]; link_pass = l[0];
                  e = fd_exp(p, f[0], a[0], l[0]);
                  rd(3, d);
                  check("R4 fd source live", 16'(d[15]), 16'(e));
                  tick();
                  check("R4 fd source pin", 16'(led_prog_n[2]), 16'(!e));
               end
   endtask

   task automatic test_link_mask();
      logic [15:0] d;
      logic        e;
      for (int s = 0; s < 2; s++) begin
         do_reset();
         if (s == 1) wr(2, 16'h0100);
         for (int p = 0; p < 4; p++)
            for (int f = 0; f < 2; f++)
               for (int a = 0; a < 2; a++)
                  for (int l = 0; l < 2; l++) begin
                     port_sel = 2'(p); fd_en = f[0]; aui_fd = a[0]; link_pass = l[0];
                     e = l[0] & !(p == 0 && f[0] && !a[0] && s == 1);
                     rd(0, d);
                     check("R9 link live read", d, {e, 15'b0});
                     tick();
                     check("R8 link pin", 16'(led_link_n), 16'(!e));
                  end
      end
   endtask

   task automatic test_rsvd_and_isolation();
      logic [15:0] d;
      do_reset();
      wr(1, 16'hFFFF);
      rd(1, d);
      check("R3 reserved bits zero", d, 16'h0384);
      rd(2, d);
      check("R10 other channel untouched", d, 16'h0084);
      wr(1, 16'h0000);
      rd(1, d);
      check("R3 all cleared", d, 16'h0000);
      wr(0, 16'hFFFF);
      rd(0, d);
      check("R10 link write ignored", d, 16'h0000);
      rd(3, d);
      check("R10 addr0 write no channel change", d, 16'h0084);
      check("R10 link pin stays off", 16'(led_link_n), 16'h1);
   endtask

   initial begin
      #1_500_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      test_reset();
      test_follow();
      test_stretch();
      test_restart();
      test_fd_ports();
      test_link_mask();
      test_rsvd_and_isolation();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule